// File: doc/BRIEF.md
# I2C Slave Byte Engine with Host Data Buffer

This block is the target side of a two-wire serial bus. Host software reaches it through a small register port with four locations: a data buffer, a status word, a control word and an interrupt-enable mask. When a bus master addresses the block for a read, the block sends bytes that software has placed in the data buffer. Each byte moves into a private shift register before it is clocked out, so software can preload the following byte while the current one is still on the wire. When the master writes to the block, each received byte is copied into the same data buffer for software to collect.

The block holds SCL low (clock stretching) whenever the master wants a byte that software has not supplied yet. It reports events through sticky status flags: transmit buffer empty, receive byte ready, not-acknowledge from the master, and stop or repeated start seen while addressed. Any flag whose enable bit is set drives the interrupt output. Both bus lines are open-drain. Each line comes in as a level and goes out as a drive-low enable. Both lines pass through a synchronizer and are processed on a system clock much faster than SCL.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset both drive-low enables are 0, the interrupt is 0 and the status word (register 1) reads 0x00.
- R2: The block acknowledges an address byte (drives SDA low in the ninth clock) only when control bit 7 (enable) is 1 and address bits [7:1] equal control bits [6:0]. On any other address it leaves SDA released and ignores the rest of the transfer.
- R3: In a write transfer each received byte is acknowledged and placed in the data register (register 0). Status bit 1 (receive ready) is set at the same time and is cleared by a host read of register 0.
- R4: While the block is addressed for a write transfer, host writes to register 0 are ignored. Once the transfer has ended, host writes to register 0 take effect again.
- R5: After acknowledging a read address with no byte pending, the block holds SCL low until the host writes register 0. It then releases SCL and sends that byte MSB first.
- R6: Status bit 0 (transmit empty) is cleared by a host write to register 0. It is set when the first bit of a byte has been clocked out (the first SCL rising edge of that byte) and no further byte is pending. It is also set whenever the block starts to stretch.
- R7: If the master acknowledges a sent byte and no new byte has been loaded, the block holds SCL low from the falling edge after that acknowledge until register 0 is written.
- R8: A not-acknowledge (SDA high in the ninth clock) after a sent byte sets status bit 2. The block then leaves SDA released until the next START or STOP.
- R9: A STOP, or a repeated START, seen while the block is addressed sets status bit 3. A host read of register 1 clears it. A STOP seen while the block is not addressed leaves it at 0.
- R10: The interrupt output is high when any status bit in [3:0] is 1 and its matching bit in register 3 is 1, and low otherwise. Writing 1 to status bit 2 or 3 through register 1 clears that bit.
- R11: The block changes its SDA drive only while SCL is low, so SDA is stable during every SCL high phase of a data or acknowledge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr | input | 1 | Host write strobe, one cycle |
| reg_rd | input | 1 | Host read strobe, one cycle (clear-on-read side effects) |
| reg_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 interrupt enable |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for the selected register; status is {0,0,read_dir,addressed,bus_end,nak,rx_ready,tx_empty} |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the timing of the transmit-empty flag. A design that raised it when the byte was loaded, rather than one bit into the byte, would show the flag set while SCL is still stretched. The bench releases SCL from the master side during a stretch and checks that the line stays low, which catches an engine that lets the master run ahead and clock out stale shift-register data. It writes the data register in the middle of a receive and reads back the received byte: a missing lock would return the host value instead. It also issues a repeated START that is followed by a non-matching address and then a STOP, which exposes a design that flags bus ends while it is not addressed.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  localparam int ADDR_BITS = 7;
  localparam int NFLAGS    = 4;

  // register select codes
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_IEN  = 2'd3;

  // status flag positions
  localparam int F_TXE  = 0;
  localparam int F_RXR  = 1;
  localparam int F_NAK  = 2;
  localparam int F_BEND = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_NEXT,
    ST_TX_WAIT,
    ST_TX_LOAD,
    ST_DONE
  } eng_state_t;

  function automatic logic addr_hit(input logic [7:0] frame,
                                    input logic [ADDR_BITS-1:0] own,
                                    input logic en);
    return en && (frame[7:1] == own);
  endfunction

  function automatic logic [7:0] shift_in(input logic [7:0] s, input logic b);
    return {s[6:0], b};
  endfunction

  function automatic logic [NFLAGS-1:0] flag_next(input logic [NFLAGS-1:0] cur,
                                                  input logic [NFLAGS-1:0] set_v,
                                                  input logic [NFLAGS-1:0] clr_v);
    return set_v | (cur & ~clr_v);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2c_slv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic                 sda_s,
  input  logic [ADDR_BITS-1:0] own_addr,
  input  logic                 slave_en,
  input  logic                 data_valid,
  input  logic [7:0]           tx_byte,
  output logic                 scl_oe,
  output logic                 sda_oe,
  output logic                 tx_load,
  output logic                 ev_tx_empty,
  output logic                 ev_rx_byte,
  output logic [7:0]           rx_byte,
  output logic                 ev_nak,
  output logic                 ev_bus_end,
  output logic                 addressed,
  output logic                 read_dir
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);

  eng_state_t       state;
  logic [7:0]       sh;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sh          <= '0;
      cnt         <= '0;
      addressed   <= 1'b0;
      read_dir    <= 1'b0;
      tx_load     <= 1'b0;
      ev_tx_empty <= 1'b0;
      ev_rx_byte  <= 1'b0;
      rx_byte     <= '0;
      ev_nak      <= 1'b0;
      ev_bus_end  <= 1'b0;
    end else begin
      tx_load     <= 1'b0;
      ev_tx_empty <= 1'b0;
      ev_rx_byte  <= 1'b0;
      ev_nak      <= 1'b0;
      ev_bus_end  <= 1'b0;
      if (start_det) begin
        ev_bus_end <= addressed;
        addressed  <= 1'b0;
        read_dir   <= 1'b0;
        cnt        <= '0;
        state      <= ST_ADDR;
      end else if (stop_det) begin
        ev_bus_end <= addressed;
        addressed  <= 1'b0;
        read_dir   <= 1'b0;
        state      <= ST_IDLE;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= shift_in(sh, sda_s);
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              if (addr_hit(sh, own_addr, slave_en)) begin
                addressed <= 1'b1;
                read_dir  <= sh[0];
                state     <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (read_dir) begin
                if (data_valid) begin
                  sh      <= tx_byte;
                  tx_load <= 1'b1;
                  state   <= ST_TX;
                end else begin
                  ev_tx_empty <= 1'b1;
                  state       <= ST_TX_WAIT;
                end
              end else begin
                state <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sh  <= shift_in(sh, sda_s);
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              rx_byte    <= sh;
              ev_rx_byte <= 1'b1;
              state      <= ST_RX_ACK;
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              cnt   <= '0;
              state <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == '0 && !data_valid) ev_tx_empty <= 1'b1;
            end else if (scl_fall) begin
              if (cnt == LAST_BIT) state <= ST_TX_ACK;
              else                 sh    <= {sh[6:0], 1'b0};
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (sda_s) begin
                ev_nak <= 1'b1;
                state  <= ST_DONE;
              end else begin
                state <= ST_TX_NEXT;
              end
            end
          end
          ST_TX_NEXT: begin
            if (scl_fall) begin
              cnt <= '0;
              if (data_valid) begin
                sh      <= tx_byte;
                tx_load <= 1'b1;
                state   <= ST_TX;
              end else begin
                ev_tx_empty <= 1'b1;
                state       <= ST_TX_WAIT;
              end
            end
          end
          ST_TX_WAIT: begin
            if (data_valid) begin
              sh      <= tx_byte;
              tx_load <= 1'b1;
              state   <= ST_TX_LOAD;
            end
          end
          ST_TX_LOAD: state <= ST_TX;
          default: ;
        endcase
      end
    end
  end

  assign scl_oe = (state == ST_TX_WAIT) || (state == ST_TX_LOAD);
  assign sda_oe = (state == ST_ADDR_ACK) || (state == ST_RX_ACK) ||
                  (((state == ST_TX) || (state == ST_TX_LOAD)) && !sh[7]);
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_slv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [1:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic                 tx_load,
  input  logic                 ev_tx_empty,
  input  logic                 ev_rx_byte,
  input  logic [7:0]           rx_byte,
  input  logic                 ev_nak,
  input  logic                 ev_bus_end,
  input  logic                 addressed,
  input  logic                 read_dir,
  output logic [7:0]           data_q,
  output logic                 data_valid,
  output logic [ADDR_BITS-1:0] own_addr,
  output logic                 slave_en,
  output logic [NFLAGS-1:0]    flags,
  output logic [NFLAGS-1:0]    ien,
  output logic                 rx_lock,
  output logic                 host_data_wr,
  output logic                 irq
);
  logic             stat_rd;
  logic             data_rd;
  logic             stat_wr;
  logic [NFLAGS-1:0] set_v;
  logic [NFLAGS-1:0] clr_v;

  assign rx_lock      = addressed && !read_dir;
  assign host_data_wr = reg_wr && (reg_addr == SEL_DATA) && !rx_lock;
  assign stat_rd      = reg_rd && (reg_addr == SEL_STAT);
  assign data_rd      = reg_rd && (reg_addr == SEL_DATA);
  assign stat_wr      = reg_wr && (reg_addr == SEL_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q     <= '0;
      data_valid <= 1'b0;
      own_addr   <= '0;
      slave_en   <= 1'b0;
      ien        <= '0;
    end else begin
      if (ev_rx_byte)        data_q <= rx_byte;
      else if (host_data_wr) data_q <= reg_wdata;
      if (host_data_wr)                  data_valid <= 1'b1;
      else if (tx_load || ev_rx_byte)    data_valid <= 1'b0;
      if (reg_wr && reg_addr == SEL_CTRL) begin
        own_addr <= reg_wdata[ADDR_BITS-1:0];
        slave_en <= reg_wdata[7];
      end
      if (reg_wr && reg_addr == SEL_IEN) ien <= reg_wdata[NFLAGS-1:0];
    end
  end

  assign set_v[F_TXE]  = ev_tx_empty;
  assign set_v[F_RXR]  = ev_rx_byte;
  assign set_v[F_NAK]  = ev_nak;
  assign set_v[F_BEND] = ev_bus_end;
  assign clr_v[F_TXE]  = host_data_wr;
  assign clr_v[F_RXR]  = data_rd;
  assign clr_v[F_NAK]  = stat_wr && reg_wdata[F_NAK];
  assign clr_v[F_BEND] = stat_rd || (stat_wr && reg_wdata[F_BEND]);

  genvar gi;
  generate
    for (gi = 0; gi < NFLAGS; gi++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[gi] <= 1'b0;
        else        flags[gi] <= flag_next(flags, set_v, clr_v)[gi];
      end
    end
  endgenerate

  assign irq = |(flags & ien);

  always_comb begin
    unique case (reg_addr)
      SEL_DATA: reg_rdata = data_q;
      SEL_STAT: reg_rdata = {2'b00, read_dir, addressed, flags};
      SEL_CTRL: reg_rdata = {slave_en, own_addr};
      default:  reg_rdata = {{(8-NFLAGS){1'b0}}, ien};
    endcase
  end
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic                 scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                 tx_load, ev_tx_empty, ev_rx_byte, ev_nak, ev_bus_end;
  logic [7:0]           rx_byte, data_q;
  logic                 addressed, read_dir, data_valid, slave_en;
  logic [ADDR_BITS-1:0] own_addr;
  logic [NFLAGS-1:0]    flags, ien;
  logic                 rx_lock, host_data_wr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .own_addr(own_addr), .slave_en(slave_en), .data_valid(data_valid),
    .tx_byte(data_q), .scl_oe(scl_oe), .sda_oe(sda_oe), .tx_load(tx_load),
    .ev_tx_empty(ev_tx_empty), .ev_rx_byte(ev_rx_byte), .rx_byte(rx_byte),
    .ev_nak(ev_nak), .ev_bus_end(ev_bus_end), .addressed(addressed),
    .read_dir(read_dir)
  );

  i2c_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_load(tx_load), .ev_tx_empty(ev_tx_empty), .ev_rx_byte(ev_rx_byte),
    .rx_byte(rx_byte), .ev_nak(ev_nak), .ev_bus_end(ev_bus_end),
    .addressed(addressed), .read_dir(read_dir), .data_q(data_q),
    .data_valid(data_valid), .own_addr(own_addr), .slave_en(slave_en),
    .flags(flags), .ien(ien), .rx_lock(rx_lock), .host_data_wr(host_data_wr),
    .irq(irq)
  );
endmodule

// File: rtl/i2c_slave_tx_chk.sv
module i2c_slave_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       addressed,
  input logic       read_dir,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       rx_lock,
  input logic       ev_rx_byte,
  input logic [7:0] data_q,
  input logic       ev_nak,
  input logic       ev_bus_end,
  input logic       ev_tx_empty,
  input logic       host_data_wr,
  input logic [3:0] flags,
  input logic [3:0] ien,
  input logic       irq
);
  assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  assert_rx_lock_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && rx_lock && !ev_rx_byte) |=> (data_q == $past(data_q)));

  assert_stretch_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (addressed && read_dir));

  assert_nak_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nak |=> flags[2]);

  assert_bus_end_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_end |=> flags[3]);

  assert_txe_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_empty && !host_data_wr) |=> flags[0]);

  assert_irq_nak_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && ien[2]) |-> irq);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 4'd0) |-> !irq);
endmodule

bind i2c_slave_tx i2c_slave_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .addressed(addressed), .read_dir(read_dir), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .rx_lock(rx_lock), .ev_rx_byte(ev_rx_byte),
  .data_q(data_q), .ev_nak(ev_nak), .ev_bus_end(ev_bus_end),
  .ev_tx_empty(ev_tx_empty), .host_data_wr(host_data_wr), .flags(flags),
  .ien(ien), .irq(irq)
);

// File: tb/tb_i2c_slave_tx.sv
`timescale 1ns/1ps
module tb_i2c_slave_tx;
  localparam int H = 40;
  localparam int WDOG = 150000;
  localparam logic [6:0] OWN = 7'h3C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       scl_bus, sda_bus;
  logic       scl_oe, sda_oe;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_slave_tx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(H / 2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(H); m_scl = 1'b1; wait_scl_high(); tick(H);
    m_sda = 1'b1; tick(H);
  endtask

  task automatic bus_restart();
    m_sda = 1'b1; tick(H); m_scl = 1'b1; wait_scl_high(); tick(H);
    m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(H / 2);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(H); m_scl = 1'b1; wait_scl_high(); tick(H); m_scl = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    logic late;
    m_sda = 1'b1; tick(H); m_scl = 1'b1; wait_scl_high();
    tick(H / 2); b = sda_bus; tick(H / 2); late = sda_bus;
    chk("R11 sda stable while scl high", late, b);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack);
  endtask

  task automatic recv_byte(input logic ackbit, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(ackbit);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    host_read(2'd1, s);
    chk("R1 status after reset", s, 8'h00);
    chk("R1 scl_oe after reset", scl_oe, 1'b0);
    chk("R1 sda_oe after reset", sda_oe, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);
  endtask

  task automatic t_wrong_addr();
    logic ack;
    logic [7:0] s;
    bus_start();
    send_byte({7'h21, 1'b0}, ack);
    chk("R2 foreign address not acked", ack, 1'b1);
    bus_stop();
    host_read(2'd1, s);
    chk("R9 no bus-end flag when unaddressed", s, 8'h00);
  endtask

  task automatic t_read();
    logic ack, b;
    logic [7:0] s, d;
    bus_start();
    send_byte({OWN, 1'b1}, ack);
    chk("R2 own read address acked", ack, 1'b0);
    tick(20);
    chk("R5 scl held after read match", scl_oe, 1'b1);
    host_read(2'd1, s);
    chk("R6 tx_empty set when stretching", s[0], 1'b1);
    chk("R5 read direction bit", s[5:4], 2'b11);
    m_scl = 1'b1;
    tick(60);
    chk("R5 scl stays low without data", scl_bus, 1'b0);
    m_scl = 1'b0;
    host_write(2'd0, 8'hC3);
    tick(6);
    chk("R5 scl released after load", scl_oe, 1'b0);
    host_read(2'd1, s);
    chk("R6 tx_empty clear before first bit", s[0], 1'b0);
    recv_bit(b);
    d[7] = b;
    tick(4);
    host_read(2'd1, s);
    chk("R6 tx_empty set after first bit", s[0], 1'b1);
    chk("R10 irq from tx_empty", irq, 1'b1);
    for (int i = 6; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    chk("R5 first byte MSB first", d, 8'hC3);
    send_bit(1'b0);
    tick(30);
    chk("R7 stretch between bytes", scl_oe, 1'b1);
    host_write(2'd0, 8'h5E);
    recv_byte(1'b1, d);
    chk("R7 second byte after stretch", d, 8'h5E);
    tick(4);
    host_read(2'd1, s);
    chk("R8 nak flag set", s[2], 1'b1);
    chk("R8 sda released after nak", sda_oe, 1'b0);
    host_write(2'd3, 8'h04);
    tick(2);
    chk("R10 irq from enabled nak", irq, 1'b1);
    host_write(2'd3, 8'h00);
    tick(2);
    chk("R10 irq masked", irq, 1'b0);
    host_write(2'd1, 8'h04);
    host_read(2'd1, s);
    chk("R10 nak cleared by write-one", s[2], 1'b0);
    host_write(2'd3, 8'h0F);
    bus_stop();
    host_read(2'd1, s);
    chk("R9 stop while addressed sets flag", s[3], 1'b1);
    host_read(2'd1, s);
    chk("R9 status read clears flag", s[3], 1'b0);
  endtask

  task automatic t_write();
    logic ack;
    logic [7:0] s, d;
    bus_start();
    send_byte({OWN, 1'b0}, ack);
    chk("R2 own write address acked", ack, 1'b0);
    host_read(2'd1, s);
    chk("R2 addressed for write", s[5:4], 2'b01);
    send_byte(8'hA5, ack);
    chk("R3 data byte acked", ack, 1'b0);
    tick(4);
    host_read(2'd1, s);
    chk("R3 receive ready set", s[1], 1'b1);
    host_write(2'd0, 8'h11);
    host_read(2'd0, d);
    chk("R4 host write blocked during receive", d, 8'hA5);
    host_read(2'd1, s);
    chk("R3 receive ready cleared by data read", s[1], 1'b0);
    send_byte(8'h3C, ack);
    tick(4);
    host_read(2'd0, d);
    chk("R3 second received byte", d, 8'h3C);
    bus_restart();
    host_read(2'd1, s);
    chk("R9 restart while addressed sets flag", s[3], 1'b1);
    host_read(2'd1, s);
    chk("R9 cleared after read", s[3], 1'b0);
    send_byte({7'h21, 1'b1}, ack);
    chk("R2 foreign address after restart", ack, 1'b1);
    bus_stop();
    host_read(2'd1, s);
    chk("R9 stop when unaddressed", s[3], 1'b0);
    host_write(2'd0, 8'h77);
    host_read(2'd0, d);
    chk("R4 host write accepted after transfer", d, 8'h77);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    host_write(2'd2, {1'b1, OWN});
    host_write(2'd3, 8'h0F);
    t_wrong_addr();
    t_read();
    t_write();
    finish_run();
  end
endmodule